// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block takes a fast clock and produces a single divided clock with a 50% duty cycle. A 2-bit ratio code selects division by 1, 2, 4 or 8. A power-down request slows the output by a further factor of 16. An active-high enable gates the output on and off.

Every change of ratio, of power-down state or of enable is adopted only where one output period ends and the next begins. As a result, the output never shows a high or low phase shorter than the old or the new ratio calls for.

For division by 1, the input clock is passed through a gate. That gate only switches while the input clock is low. For every other ratio, the output is a registered toggle.

The reset input is asynchronous and active low. Its release is synchronised to the fast clock inside the block. The ratio code, enable and power-down inputs are expected to be synchronous to the fast clock.

Top module: `clk_out_div`

## Requirements
- R1: The ratio code selects the output period in input-clock cycles: code 00 gives 2, code 01 gives 4, code 10 gives 8 and code 11 gives 1.
- R2: For every ratio of 2 or more, the output stays high for exactly half the period and low for exactly half the period.
- R3: With code 11, enabled and not powered down, the output reproduces the input clock: it is high while the input clock is high and low while the input clock is low.
- R4: While power-down is asserted, the output period is 16 times the period the code selects, with the duty cycle still 50%. Code 11 with power-down gives 16 cycles, code 00 gives 32, and code 10 gives 128.
- R5: When the enable is low, the output is held low. A disable that arrives during a high phase lets that phase finish at full length.
- R6: A new ratio code or power-down state is adopted only at the end of a complete output period. Every high phase seen on the output equals either the old or the new half-period, so no runt appears.
- R7: Re-enabling the output, or leaving power-down, takes effect at a period boundary. The first high phase afterwards has the full length of the new ratio.
- R8: While reset is asserted the output is low, and the divider restarts from a period boundary after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code_i | input | 2 | Ratio code: 00 = /2, 01 = /4, 10 = /8, 11 = /1 |
| en_i | input | 1 | Active-high output enable |
| pwr_dn_i | input | 1 | Power-down request: divides the output by a further 16 |
| clk_o | output | 1 | Divided output clock |

## Verification
The embedded assertions watch the period controller on every cycle:
- a high phase of the toggle always ends at the half-period count;
- a low phase in divided mode ends at the same count;
- the ratio register moves only at the end of a low phase;
- disabling never cuts a high phase;
- the pass-through gate and the toggle are never driven together.

Behaviour that depends on the pass-through gate and the true output waveform can only be shown by the bench's scenarios. This includes the exact output period for each code and power-down combination, division by 1 following the input clock, the low hold while disabled, and the absence of runts across each mode change. The bench measures these in half-cycle steps.

// File: rtl/clk_out_div_pkg.sv
package clk_out_div_pkg;

  typedef enum logic [1:0] {
    RC_DIV2 = 2'b00,
    RC_DIV4 = 2'b01,
    RC_DIV8 = 2'b10,
    RC_DIV1 = 2'b11
  } ratio_code_e;

  // log2 of the base division selected by a ratio code
  function automatic logic [1:0] base_log2(input logic [1:0] code);
    logic [1:0] r;
    case (ratio_code_e'(code))
      RC_DIV2: r = 2'd1;
      RC_DIV4: r = 2'd2;
      RC_DIV8: r = 2'd3;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clk_out_div_rst_sync.sv
module clk_out_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clk_out_div_decode.sv
module clk_out_div_decode
  import clk_out_div_pkg::*;
#(
  parameter int PD_SHIFT = 4,
  parameter int KW       = 3
) (
  input  logic [1:0]    ratio_code_i,
  input  logic          pwr_dn_i,
  output logic [KW-1:0] k_o
);
  logic [KW-1:0] base_k;
  logic [KW-1:0] pd_k;

  always_comb begin
    base_k = KW'(base_log2(ratio_code_i));
    pd_k   = pwr_dn_i ? KW'(PD_SHIFT) : '0;
    k_o    = base_k + pd_k;
  end
endmodule

// File: rtl/clk_out_div_ctrl.sv
module clk_out_div_ctrl #(
  parameter int KW    = 3,
  parameter int CNT_W = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [KW-1:0] k_new_i,
  output logic          tog_o,
  output logic          pass_req_o
);
  logic             act_q, act_d;
  logic [KW-1:0]    k_q, k_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic [CNT_W-1:0] half_m1;
  logic             at_end;
  logic             bnd;

  always_comb begin
    if (k_q == '0) half_m1 = '0;
    else           half_m1 = CNT_W'((32'd1 << (32'(k_q) - 32'd1)) - 32'd1);
  end

  always_comb begin
    at_end = (cnt_q == half_m1);
    bnd    = !act_q || (k_q == '0) || (!tog_q && at_end);
    act_d  = act_q;
    k_d    = k_q;
    cnt_d  = cnt_q;
    tog_d  = tog_q;
    if (bnd) begin
      act_d = en_i;
      k_d   = k_new_i;
      cnt_d = '0;
      tog_d = en_i && (k_new_i != '0);
    end else if (at_end) begin
      cnt_d = '0;
      tog_d = ~tog_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      k_q   <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      act_q <= act_d;
      k_q   <= k_d;
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign tog_o      = tog_q;
  assign pass_req_o = act_q && (k_q == '0);

  // R2: a high phase ends only after the full half-period count
  assert_high_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tog_q) |-> ($past(cnt_q) == $past(half_m1)));

  // R6: in divided mode a new high phase starts only after a full low phase
  assert_low_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tog_q) && $past(act_q) && ($past(k_q) != '0)) |->
      ($past(cnt_q) == $past(half_m1)));

  // R6: the ratio moves only at the end of a low phase
  assert_adopt_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((k_q != $past(k_q)) && $past(act_q) && ($past(k_q) != '0)) |->
      (!$past(tog_q) && ($past(cnt_q) == $past(half_m1))));

  // R5: disabling never cuts a high phase
  assert_disable_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> !$past(tog_q));
endmodule

// File: rtl/clk_out_div_gate.sv
module clk_out_div_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_req_i,
  output logic gate_o
);
  logic gate_q;

  // updated on the falling edge so the pass gate only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= pass_req_i;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clk_out_div.sv
module clk_out_div #(
  parameter int PD_SHIFT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ratio_code_i,
  input  logic       en_i,
  input  logic       pwr_dn_i,
  output logic       clk_o
);
  localparam int KMAX  = 3 + PD_SHIFT;
  localparam int KW    = $clog2(KMAX + 1);
  localparam int CNT_W = (KMAX > 1) ? KMAX - 1 : 1;

  logic          rst_sync_n;
  logic [KW-1:0] k_new;
  logic          tog;
  logic          pass_req;
  logic          gate;

  clk_out_div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  clk_out_div_decode #(.PD_SHIFT(PD_SHIFT), .KW(KW)) u_dec (
    .ratio_code_i (ratio_code_i),
    .pwr_dn_i     (pwr_dn_i),
    .k_o          (k_new)
  );

  clk_out_div_ctrl #(.KW(KW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .en_i       (en_i),
    .k_new_i    (k_new),
    .tog_o      (tog),
    .pass_req_o (pass_req)
  );

  clk_out_div_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .pass_req_i (pass_req),
    .gate_o     (gate)
  );

  assign clk_o = tog | (clk_i & gate);

  // R3: the pass-through gate and the toggle never drive the output together
  assert_gate_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(gate && tog));
endmodule

// File: tb/clk_out_div_tb.sv
module clk_out_div_tb;
  logic       clk;
  logic       rst_n;
  logic [1:0] code;
  logic       en;
  logic       pd;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int ok_a = 2, ok_b = 2;
  bit armed = 0, started = 0, last = 0, done = 0;
  int run_len = 0;
  string cur_tag = "R1";

  clk_out_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_code_i(code),
    .en_i(en), .pwr_dn_i(pd), .clk_o(clk_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int period_of(input logic [1:0] c, input logic p);
    int b;
    case (c)
      2'b00: b = 2;
      2'b01: b = 4;
      2'b10: b = 8;
      default: b = 1;
    endcase
    return p ? b * 16 : b;
  endfunction

  function automatic void tick();
    bit v;
    int e;
    v = clk_o;
    if (!rst_n) begin last = 0; run_len = 0; return; end
    if (v == last) begin run_len++; return; end
    if (last) begin
      checks++;
      if (run_len != ok_a && run_len != ok_b) begin
        fails++;
        $display("FAIL R6 runt high phase: actual %0d half-cycles, expected %0d or %0d",
                 run_len, ok_a, ok_b);
      end
    end
    if (armed) begin
      if (!started) begin
        if (v) started = 1;
      end else if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (run_len != e) begin
          fails++;
          $display("FAIL %s phase length: actual %0d half-cycles, expected %0d",
                   cur_tag, run_len, e);
        end
      end
    end
    run_len = 1;
    last = v;
  endfunction

  // monitor: one sample in each half of every input cycle
  initial forever begin
    @(posedge clk); #5; tick();
    @(negedge clk); #5; tick();
  end

  task automatic run_mode(input logic [1:0] c, input logic p, input string tag, input int n);
    int d;
    d = period_of(c, p);
    ok_b = d;
    @(negedge clk); #1;
    code = c; pd = p; en = 1'b1;
    cur_tag = tag;
    repeat (2) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(d);
      exp_q.push_back(d);
    end
    started = 0;
    armed = 1;
    while (exp_q.size() > 0) @(posedge clk);
    armed = 0;
    ok_a = d;
  endtask

  task automatic hold_low(input string tag);
    @(negedge clk); #1;
    en = 1'b0;
    repeat (300) @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #7;
      checks++;
      if (clk_o !== 1'b0) begin
        fails++;
        $display("FAIL %s output while disabled: actual %b expected 0", tag, clk_o);
      end
      @(negedge clk); #7;
      checks++;
      if (clk_o !== 1'b0) begin
        fails++;
        $display("FAIL %s output while disabled: actual %b expected 0", tag, clk_o);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; code = 2'b00; en = 1'b1; pd = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #7;
      checks++;
      if (clk_o !== 1'b0) begin
        fails++;
        $display("FAIL R8 output in reset: actual %b expected 0", clk_o);
      end
    end
    @(negedge clk); #1;
    rst_n = 1'b1;
    run_mode(2'b00, 1'b0, "R8", 2);
    run_mode(2'b00, 1'b0, "R1", 4);
    run_mode(2'b01, 1'b0, "R1", 4);
    run_mode(2'b10, 1'b0, "R2", 4);
    run_mode(2'b11, 1'b0, "R3", 8);
    run_mode(2'b11, 1'b1, "R4", 3);
    run_mode(2'b00, 1'b1, "R4", 2);
    run_mode(2'b01, 1'b0, "R7", 4);
    run_mode(2'b10, 1'b1, "R4", 2);
    run_mode(2'b11, 1'b0, "R6", 6);
    run_mode(2'b10, 1'b0, "R6", 3);
    hold_low("R5");
    run_mode(2'b01, 1'b0, "R7", 3);
    run_mode(2'b11, 1'b0, "R3", 4);
    hold_low("R5");
    run_mode(2'b00, 1'b0, "R7", 3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule